// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block takes one asynchronous serial line and turns its character frames into bytes held in a small receive queue for the host. It runs entirely on the system clock. An external enable pulse, `os_tick`, arrives at sixteen times the bit rate, and every timing decision inside the receiver is counted in those ticks. A falling edge on the idle line is only accepted as a start bit if the line is still low half a bit later. Each following bit is then sampled once, near its centre. Before any of this, the line passes through a two-flop synchroniser.

The character format is chosen at run time with four configuration inputs: seven or eight data bits, parity off, even or odd, and one or two stop bits. The receiver captures the format when a start bit is confirmed, so a change made during a character only affects the next one. Each word goes into the queue with two flags. One marks a parity mismatch and one marks a stop bit that read low. The queue holds eight words. The host pulls words out one at a time with a read strobe and gets the oldest word back on the next cycle. A word that arrives while the queue is full is thrown away and raises a sticky overrun flag.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset `data_avail`, `fifo_full`, `overrun` and `rd_valid` are all 0.
- R2: A low line seen on a tick while idle is checked again 8 ticks later. If the line is high by then, the receiver goes back to idle and no word is stored.
- R3: After a confirmed start bit, data bits are sampled every 16 ticks, least significant bit first. With `cfg_eight_bits`=1 the stored byte equals the eight transmitted bits.
- R4: With `cfg_eight_bits`=0 seven data bits are received. Bit 7 of the stored byte is 0 and bits 6..0 hold the received bits.
- R5: With `cfg_parity_en`=1 one parity bit follows the data. `cfg_parity_odd`=0 selects even parity (data ones plus parity bit is even) and `cfg_parity_odd`=1 selects odd parity. A mismatch sets the stored parity flag. With parity off the flag is always 0.
- R6: The stop bit is sampled at its centre and a low value sets the stored framing flag. With `cfg_two_stop`=1 both stop bits are sampled and either one low sets the flag. The word is stored whether the flag is set or not.
- R7: The queue holds 8 words and returns them in arrival order. `fifo_full` is 1 while 8 words are held.
- R8: A word completed while the queue is full is discarded and `overrun` is set to 1. `overrun` stays 1 until reset.
- R9: `rd_en` while `data_avail`=1 gives `rd_valid`=1 on the next cycle, with the oldest word on `rd_data`, `rd_parity_err` and `rd_frame_err`. `rd_en` on an empty queue is ignored. `data_avail` falls once the last word has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity_en | input | 1 | 1: a parity bit follows the data |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| rd_en | input | 1 | Read strobe for the receive queue |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 8 | Received byte |
| rd_parity_err | output | 1 | Parity mismatch flag of the word read |
| rd_frame_err | output | 1 | Low stop bit flag of the word read |
| data_avail | output | 1 | Queue holds at least one word |
| fifo_full | output | 1 | Queue holds eight words |
| overrun | output | 1 | Sticky: a word was lost to a full queue |

## Verification
A word enters the queue on the clock after the tick that samples its last stop bit. `data_avail` rises on that same clock, so the bench checks the queue flags only once a whole frame, including the stop bits, has been driven on the line. Read results come out exactly one cycle after `rd_en`. The monitor samples `rd_valid` on the falling edge and compares each result with the head of the expected-word queue. A false start and an overrun produce no word at all. For both, the bench waits for at least a full frame time and then checks at the ports that no word arrived and that nothing extra is left queued.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx,
  input  logic     cfg_eight_bits,
  input  logic     cfg_parity_en,
  input  logic     cfg_parity_odd,
  input  logic     cfg_two_stop,
  output logic     push,
  output rx_word_t word
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(BYTE_W);

  rx_state_e         state_q;
  logic [CW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              len8_q, par_en_q, par_odd_q, stop2_q;
  logic              pbit_q, ferr_acc_q;
  logic              push_q;
  rx_word_t          word_q;

  logic              bit_end;
  logic              half_end;
  logic [BW-1:0]     last_bit;
  logic [BYTE_W-1:0] data_final;
  logic              perr_calc;

  assign bit_end    = (tcnt_q == CW'(OSR - 1));
  assign half_end   = (tcnt_q == CW'(HALF - 1));
  assign last_bit   = len8_q ? BW'(BYTE_W - 1) : BW'(BYTE_W - 2);
  assign data_final = len8_q ? shreg_q : {1'b0, shreg_q[BYTE_W-1:1]};
  assign perr_calc  = par_en_q & ((^data_final ^ pbit_q) != par_odd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      shreg_q    <= '0;
      len8_q     <= 1'b1;
      par_en_q   <= 1'b0;
      par_odd_q  <= 1'b0;
      stop2_q    <= 1'b0;
      pbit_q     <= 1'b0;
      ferr_acc_q <= 1'b0;
      push_q     <= 1'b0;
      word_q     <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            tcnt_q <= '0;
            if (!rx) state_q <= ST_START;
          end
          ST_START: begin
            if (half_end) begin
              tcnt_q <= '0;
              if (rx) begin
                state_q <= ST_IDLE;
              end else begin
                state_q   <= ST_DATA;
                bcnt_q    <= '0;
                len8_q    <= cfg_eight_bits;
                par_en_q  <= cfg_parity_en;
                par_odd_q <= cfg_parity_odd;
                stop2_q   <= cfg_two_stop;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              tcnt_q  <= '0;
              shreg_q <= {rx, shreg_q[BYTE_W-1:1]};
              if (bcnt_q == last_bit) state_q <= par_en_q ? ST_PAR : ST_STOP1;
              else                    bcnt_q  <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              tcnt_q  <= '0;
              pbit_q  <= rx;
              state_q <= ST_STOP1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP1: begin
            if (bit_end) begin
              tcnt_q <= '0;
              if (stop2_q) begin
                ferr_acc_q <= ~rx;
                state_q    <= ST_STOP2;
              end else begin
                push_q      <= 1'b1;
                word_q.data <= data_final;
                word_q.perr <= perr_calc;
                word_q.ferr <= ~rx;
                state_q     <= ST_IDLE;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            if (bit_end) begin
              tcnt_q      <= '0;
              push_q      <= 1'b1;
              word_q.data <= data_final;
              word_q.perr <= perr_calc;
              word_q.ferr <= ferr_acc_q | ~rx;
              state_q     <= ST_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign push = push_q;
  assign word = word_q;

  AST_FALSE_START_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && tick && half_end && rx) |=> (state_q == ST_IDLE)); // R2

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    push_q |=> !push_q); // R6

  AST_PERR_OFF: assert property (@(posedge clk) disable iff (rst)
    (push_q && !par_en_q) |-> !word_q.perr); // R5

  AST_SEVEN_BIT_TOP: assert property (@(posedge clk) disable iff (rst)
    (push_q && !len8_q) |-> !word_q.data[BYTE_W-1]); // R4
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  rx_word_t wr_word,
  input  logic     rd_en,
  output logic     rd_valid,
  output rx_word_t rd_word,
  output logic     empty,
  output logic     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNT_W-1:0] count_q;
  logic            wr_ok, rd_ok;
  rx_word_t        rd_word_q;
  logic            rd_valid_q;

  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_word_q <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q       <= '0;
      rp_q       <= '0;
      count_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_ok;
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_word  = rd_word_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH)); // R7

  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(count_q)); // R8

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid_q); // R9
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_serial,
  input  logic              os_tick,
  input  logic              cfg_eight_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_parity_err,
  output logic              rd_frame_err,
  output logic              data_avail,
  output logic              fifo_full,
  output logic              overrun
);
  logic     rx_s;
  logic     push;
  rx_word_t word;
  rx_word_t rd_word;
  logic     empty, full;
  logic     overrun_q;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_serial),
    .d_out (rx_s)
  );

  srx_frame #(.OSR(OSR)) u_frame (
    .clk            (clk),
    .rst            (rst),
    .tick           (os_tick),
    .rx             (rx_s),
    .cfg_eight_bits (cfg_eight_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_two_stop   (cfg_two_stop),
    .push           (push),
    .word           (word)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push),
    .wr_word  (word),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .empty    (empty),
    .full     (full)
  );

  always_ff @(posedge clk) begin
    if (rst)              overrun_q <= 1'b0;
    else if (push && full) overrun_q <= 1'b1;
  end

  assign rd_data       = rd_word.data;
  assign rd_parity_err = rd_word.perr;
  assign rd_frame_err  = rd_word.ferr;
  assign data_avail    = ~empty;
  assign fifo_full     = full;
  assign overrun       = overrun_q;

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_q |=> overrun_q); // R8

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_q) |-> $past(push && full)); // R8
endmodule

// File: tb/serial_rx_fifo_tb_top.sv
module serial_rx_fifo_tb_top;
  localparam int TDIV   = 4;
  localparam int OSR    = 16;
  localparam int BITCLK = TDIV * OSR;
  localparam int WDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_serial;
  logic       os_tick;
  logic       cfg_eight_bits, cfg_parity_en, cfg_parity_odd, cfg_two_stop;
  logic       rd_en;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_parity_err, rd_frame_err;
  logic       data_avail, fifo_full, overrun;

  int checks = 0;
  int errors = 0;
  logic auto_read = 1'b0;
  logic force_rd  = 1'b0;
  logic [9:0] exp_q [$];

  always #4 clk = ~clk;

  serial_rx_fifo dut_i (
    .clk            (clk),
    .rst            (rst),
    .rx_serial      (rx_serial),
    .os_tick        (os_tick),
    .cfg_eight_bits (cfg_eight_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_two_stop   (cfg_two_stop),
    .rd_en          (rd_en),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .rd_parity_err  (rd_parity_err),
    .rd_frame_err   (rd_frame_err),
    .data_avail     (data_avail),
    .fifo_full      (fifo_full),
    .overrun        (overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    os_tick = 1'b0;
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        os_tick = (i == TDIV - 1);
      end
    end
  end

  // Monitor: reads when allowed, compares each result with the queue head
  initial begin
    rd_en = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected rd_valid", 1, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({rd_data, rd_parity_err, rd_frame_err} == e, "R3/R5/R6/R7",
                "word", int'({rd_data, rd_parity_err, rd_frame_err}), int'(e));
        end
      end
      rd_en = force_rd | (auto_read & data_avail & ~rd_en);
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic line_bit(input logic v);
    rx_serial = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit len8, input bit par,
                            input bit odd, input bit two, input bit bad_par,
                            input bit bad_s1, input bit bad_s2, input bit store);
    logic [7:0] dm;
    logic pb;
    dm = len8 ? d : {1'b0, d[6:0]};
    cfg_eight_bits = len8;
    cfg_parity_en  = par;
    cfg_parity_odd = odd;
    cfg_two_stop   = two;
    pb = (^dm) ^ odd ^ bad_par;
    if (store) exp_q.push_back({dm, par & bad_par, bad_s1 | (two & bad_s2)});
    line_bit(1'b0);
    for (int b = 0; b < (len8 ? 8 : 7); b++) line_bit(d[b]);
    if (par) line_bit(pb);
    line_bit(~bad_s1);
    if (two) line_bit(~bad_s2);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  initial begin
    rst = 1'b1;
    rx_serial = 1'b1;
    cfg_eight_bits = 1'b1;
    cfg_parity_en = 1'b0;
    cfg_parity_odd = 1'b0;
    cfg_two_stop = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(data_avail == 0, "R1", "data_avail", data_avail, 0);
    check(fifo_full == 0, "R1", "fifo_full", fifo_full, 0);
    check(overrun == 0, "R1", "overrun", overrun, 0);
    check(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);

    // R9: read on empty queue ignored
    force_rd = 1'b1;
    @(negedge clk);
    force_rd = 1'b0;
    @(negedge clk);
    check(rd_valid == 0, "R9", "rd_valid after empty read", rd_valid, 0);

    auto_read = 1'b1;
    // R3: eight bits, no parity, one stop
    send_frame(8'h55, 1, 0, 0, 0, 0, 0, 0, 1);
    send_frame(8'hA3, 1, 0, 0, 0, 0, 0, 0, 1);
    send_frame(8'h00, 1, 0, 0, 0, 0, 0, 0, 1);
    send_frame(8'hFF, 1, 0, 0, 0, 0, 0, 0, 1);
    // R4: seven bits, top bit forced to 0
    send_frame(8'hFF, 0, 0, 0, 0, 0, 0, 0, 1);
    send_frame(8'h2C, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: parity even/odd, good and bad
    send_frame(8'h5B, 1, 1, 0, 0, 0, 0, 0, 1);
    send_frame(8'h5B, 1, 1, 0, 0, 1, 0, 0, 1);
    send_frame(8'h3C, 1, 1, 1, 0, 0, 0, 0, 1);
    send_frame(8'h3C, 1, 1, 1, 0, 1, 0, 0, 1);
    send_frame(8'h41, 0, 1, 1, 0, 1, 0, 0, 1);
    // R6: stop bit errors
    send_frame(8'h96, 1, 0, 0, 0, 0, 1, 0, 1);
    send_frame(8'h69, 1, 0, 0, 1, 0, 0, 0, 1);
    send_frame(8'h69, 1, 0, 0, 1, 0, 0, 1, 1);
    send_frame(8'hC3, 1, 1, 0, 1, 0, 1, 0, 1);

    // R2: false start of 3 ticks, then idle for a frame
    rx_serial = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_serial = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    check(data_avail == 0, "R2", "data_avail after false start", data_avail, 0);
    check(exp_q.size() == 0, "R2", "pending words", exp_q.size(), 0);
    send_frame(8'hE7, 1, 0, 0, 0, 0, 0, 0, 1);

    // R7/R8: fill the queue without reading
    auto_read = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) send_frame(8'(8'h10 + k), 1, 0, 0, 0, 0, 0, 0, 1);
    check(fifo_full == 1, "R7", "fifo_full after 8 words", fifo_full, 1);
    check(overrun == 0, "R8", "overrun before loss", overrun, 0);
    send_frame(8'hEE, 1, 0, 0, 0, 0, 0, 0, 0);
    check(overrun == 1, "R8", "overrun after loss", overrun, 1);
    check(fifo_full == 1, "R8", "fifo_full after loss", fifo_full, 1);

    // R9: drain
    auto_read = 1'b1;
    repeat (40) @(negedge clk);
    check(data_avail == 0, "R9", "data_avail after drain", data_avail, 0);
    check(exp_q.size() == 0, "R7", "words still expected", exp_q.size(), 0);
    check(overrun == 1, "R8", "overrun sticky", overrun, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule